// File: doc/BRIEF.md
# Indirect PCI Configuration Access Port

This block gives a host a two-port path into the configuration registers of one emulated PCI function. The host first writes a 32-bit selector to the address port. The selector names a bus, a device, a function and a dword register. An access to the data port then reads or writes the chosen dword. The block holds a small configuration table for a single function, which sits at a bus, device and function position fixed by parameters. The table has four live entries: the identity dword, the command register, the I/O base address register and a set of reserved dwords.

A selector whose enable bit is clear, or one that points at any other bus, device or function, addresses no target. A data-port read through such a selector returns all ones, and a data-port write through it changes nothing. Inside the emulated function, only the command register and the base address register take writes. All other dwords are read-only.

Reads are registered. A read strobe in one cycle puts the result on the read-data port after the next clock edge, and the value stays there until the next read. The host issues at most one strobe per cycle.

Top module: `cfg_access_port`

## Requirements
- R1: After reset the selector is zero. A read of the address port (I/O address 0xCF8) returns the selector.
- R2: A write to the address port stores all 32 bits of the selector. The selector fields are: bit 31 enable, bits 23:16 bus, bits 15:11 device, bits 10:8 function, bits 7:2 dword index. Bits 1:0 have no effect on which dword is addressed.
- R3: A data-port read (I/O address 0xCFC) of dword 0 of the present function returns the device ID 0x8139 in bits 31:16 and the vendor ID 0x10EC in bits 15:0.
- R4: When the selector's bus, device or function does not match the present function (default bus 0, device 3, function 0), a data-port read returns 0xFFFFFFFF and a data-port write changes no register.
- R5: When the selector's enable bit is 0, a data-port read returns 0xFFFFFFFF and a data-port write changes no register.
- R6: Dword 1 holds the command register in bits 15:0, with bits 31:16 reading 0. The command register resets to 0. Only bit 0 (I/O enable) and bit 2 (bus-master enable) are writable, so a read-modify-write that sets bit 2 keeps bit 0.
- R7: Dword 4 is the I/O base address register. It resets to 0x0000C001. Bits 31:8 are writable. Bits 7:2 and bit 1 read 0, and bit 0 reads 1 to flag I/O space, so masking off the two low bits gives the base address.
- R8: All other dwords of the present function read 0 and ignore writes.
- R9: Read data appears on io_rdata one clock edge after the read strobe and holds until the next read. A read of any I/O address other than the two ports returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Registered read data |

## Verification
A corrupted selector shows up on the next read of the address port, and on the next data-port read as the wrong dword or as a false all-ones result. A bad match on bus, device or function lets a write reach the command or base register when it should not. That fault stays hidden until a later read through a valid selector shows the changed value. The bench therefore reads each writable register back after every stray write. A wrong command mask or wrong base-address flag bits are visible on the first read that follows the write.

// File: rtl/cfg_port_pkg.sv
// Shared selector layout and dword indices for the configuration access port.
// Assumes one 32-bit selector; field positions follow the standard decoding.
package cfg_port_pkg;

    localparam int SEL_DW_W = 6;

    typedef struct packed {
        logic                en;
        logic [6:0]          rsvd;
        logic [7:0]          bus;
        logic [4:0]          dev;
        logic [2:0]          fn;
        logic [SEL_DW_W-1:0] dw;
        logic [1:0]          byte_lo;
    } cfg_sel_t;

    localparam logic [SEL_DW_W-1:0] DW_IDENT = 6'd0;
    localparam logic [SEL_DW_W-1:0] DW_CMD   = 6'd1;
    localparam logic [SEL_DW_W-1:0] DW_BASE  = 6'd4;

endpackage

// File: rtl/cfg_sel_reg.sv
// Holds the selector that the address port writes.
// Assumes the write strobe already carries the address decode; resets to zero.
module cfg_sel_reg
    import cfg_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output cfg_sel_t    sel
);

    // Latch the whole selector word on an address-port write.
    always_ff @(posedge clk) begin
        if (!rst_n)     sel <= '0;
        else if (wr_en) sel <= cfg_sel_t'(wdata);
    end

    // R1
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel));

    // R2
    sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sel == cfg_sel_t'($past(wdata))));

endmodule

// File: rtl/cfg_func_regs.sv
// Configuration table of the single emulated function.
// Assumes wr is asserted only for a present, enabled target; read is combinational.
module cfg_func_regs
    import cfg_port_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h10EC,
    parameter logic [15:0] DEVICE_ID  = 16'h8139,
    parameter logic [15:0] CMD_WMASK  = 16'h0005,
    parameter int          BASE_ALIGN = 8,
    parameter logic [31:0] BASE_INIT  = 32'h0000C000,
    parameter bit          BASE_IS_IO = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [SEL_DW_W-1:0] dw,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata
);

    localparam logic [31:0] BASE_WMASK = ~((32'h1 << BASE_ALIGN) - 32'h1);
    localparam logic [31:0] BASE_FLAGS = {31'h0, BASE_IS_IO};

    logic [15:0] cmd_q;
    logic [31:0] base_q;
    logic        cmd_we;
    logic        base_we;

    assign cmd_we  = wr && (dw == DW_CMD);
    assign base_we = wr && (dw == DW_BASE);

    // Command register: only the masked bits take writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (cmd_we) cmd_q <= wdata[15:0] & CMD_WMASK;
    end

    // Base address register: only the aligned upper bits take writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= BASE_INIT & BASE_WMASK;
        else if (base_we) base_q <= wdata & BASE_WMASK;
    end

    // Read multiplexer over the dword index.
    always_comb begin
        case (dw)
            DW_IDENT: rdata = {DEVICE_ID, VENDOR_ID};
            DW_CMD:   rdata = {16'h0, cmd_q};
            DW_BASE:  rdata = base_q | BASE_FLAGS;
            default:  rdata = '0;
        endcase
    end

    // R6
    cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> $stable(cmd_q));

    // R7
    base_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !base_we |=> $stable(base_q));

    // R6
    cmd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> (cmd_q == ($past(wdata[15:0]) & CMD_WMASK)));

endmodule

// File: rtl/cfg_access_port.sv
// Two-port indirect configuration access: an address port latches a selector,
// and a data port reads or writes the selected dword of one emulated function.
// Assumes at most one of io_rd and io_wr per cycle, with dword-wide accesses.
module cfg_access_port
    import cfg_port_pkg::*;
#(
    parameter int          IO_AW     = 16,
    parameter logic [15:0] ADDR_PORT = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC,
    parameter logic [7:0]  FN_BUS    = 8'd0,
    parameter logic [4:0]  FN_DEV    = 5'd3,
    parameter logic [2:0]  FN_FUNC   = 3'd0,
    parameter logic [15:0] VENDOR_ID = 16'h10EC,
    parameter logic [15:0] DEVICE_ID = 16'h8139
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IO_AW-1:0] io_addr,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [31:0]      io_wdata,
    output logic [31:0]      io_rdata
);

    localparam logic [31:0] ABSENT = '1;

    cfg_sel_t    sel;
    logic        at_addr;
    logic        at_data;
    logic        present;
    logic [31:0] fn_rdata;

    assign at_addr = (io_addr == ADDR_PORT[IO_AW-1:0]);
    assign at_data = (io_addr == DATA_PORT[IO_AW-1:0]);

    // Target match: the enable bit set and the position equal to the function's.
    assign present = sel.en && (sel.bus == FN_BUS) && (sel.dev == FN_DEV)
                     && (sel.fn == FN_FUNC);

    cfg_sel_reg u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (io_wr && at_addr),
        .wdata (io_wdata),
        .sel   (sel)
    );

    cfg_func_regs #(
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (io_wr && at_data && present),
        .dw    (sel.dw),
        .wdata (io_wdata),
        .rdata (fn_rdata)
    );

    // Register the read result of the port that was strobed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_rdata <= '0;
        end else if (io_rd) begin
            if (at_addr)                 io_rdata <= sel;
            else if (at_data && present) io_rdata <= fn_rdata;
            else                         io_rdata <= ABSENT;
        end
    end

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));

    // R4
    absent_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && at_data && !present) |=> (io_rdata == ABSENT));

    // R1
    sel_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && at_addr) |=> (io_rdata == $past(sel)));

endmodule

// File: tb/test_cfg_access_port.sv
module test_cfg_access_port;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] AP = 16'h0CF8;
    localparam logic [15:0] DP = 16'h0CFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_sel;
    logic [15:0] m_cmd;
    logic [31:0] m_base;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_access_port i_cfg_access_port (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    function automatic logic [31:0] mk_sel(bit en, int bus, int dev, int fn, int dw);
        return {en, 7'h0, 8'(bus), 5'(dev), 3'(fn), 6'(dw), 2'b00};
    endfunction

    function automatic bit m_present();
        return m_sel[31] && m_sel[23:16] == 8'd0 && m_sel[15:11] == 5'd3 && m_sel[10:8] == 3'd0;
    endfunction

    function automatic logic [31:0] m_read(logic [15:0] a);
        if (a == AP) return m_sel;
        if (a != DP || !m_present()) return 32'hFFFFFFFF;
        case (m_sel[7:2])
            6'd0: return 32'h8139_10EC;
            6'd1: return {16'h0, m_cmd};
            6'd4: return m_base;
            default: return 32'h0;
        endcase
    endfunction

    function automatic void m_write(logic [15:0] a, logic [31:0] d);
        if (a == AP) m_sel = d;
        else if (a == DP && m_present()) begin
            if (m_sel[7:2] == 6'd1) m_cmd = d[15:0] & 16'h0005;
            else if (m_sel[7:2] == 6'd4) m_base = (d & 32'hFFFFFF00) | 32'h1;
        end
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic io_write(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        m_write(a, d);
    endtask

    task automatic io_read(logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic rd_chk(string tag, logic [15:0] a);
        logic [31:0] d;
        io_read(a, d);
        check(tag, d, m_read(a));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int seed;
        seed = 1234;
        void'($urandom(seed));
        m_sel = '0; m_cmd = '0; m_base = 32'h0000C001;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset selector reads zero
        io_read(AP, d); check("R1 reset selector", d, 32'h0);
        // R5 enable clear reads all ones
        io_read(DP, d); check("R5 disabled read", d, 32'hFFFFFFFF);
        // R3 identity dword
        io_write(AP, mk_sel(1, 0, 3, 0, 0));
        io_read(DP, d); check("R3 identity", d, 32'h8139_10EC);
        // R2 byte bits ignored, selector readback
        io_write(AP, mk_sel(1, 0, 3, 0, 0) | 32'h3);
        io_read(AP, d); check("R2 selector readback", d, 32'h8000_1803);
        io_read(DP, d); check("R2 low bits ignored", d, 32'h8139_10EC);
        // R6 command reset and read-modify-write of bus master
        io_write(AP, mk_sel(1, 0, 3, 0, 1));
        io_read(DP, d); check("R6 command reset", d, 32'h0);
        io_write(DP, 32'h1);
        io_read(DP, d);
        io_write(DP, d | 32'h4);
        io_read(DP, d); check("R6 rmw bus master", d, 32'h5);
        io_write(DP, 32'hFFFFFFFF);
        io_read(DP, d); check("R6 command mask", d, 32'h5);
        io_write(DP, 32'h0);
        // R7 base register
        io_write(AP, mk_sel(1, 0, 3, 0, 4));
        io_read(DP, d); check("R7 base reset", d, 32'h0000C001);
        io_write(DP, 32'hFFFFFFFF);
        io_read(DP, d); check("R7 base mask", d, 32'hFFFFFF01);
        check("R7 base masked flags", d & ~32'h3, 32'hFFFFFF00);
        io_write(DP, 32'h0000D000);
        // R8 reserved dword
        io_write(AP, mk_sel(1, 0, 3, 0, 2));
        io_write(DP, 32'hDEADBEEF);
        io_read(DP, d); check("R8 reserved dword", d, 32'h0);
        // R4 absent device and ignored write
        io_write(AP, mk_sel(1, 0, 4, 0, 1));
        io_read(DP, d); check("R4 absent read", d, 32'hFFFFFFFF);
        io_write(DP, 32'h5);
        io_write(AP, mk_sel(1, 1, 3, 0, 4));
        io_write(DP, 32'h12345600);
        io_write(AP, mk_sel(1, 0, 3, 0, 1));
        io_read(DP, d); check("R4 absent write ignored cmd", d, 32'h0);
        io_write(AP, mk_sel(1, 0, 3, 0, 4));
        io_read(DP, d); check("R4 absent write ignored base", d, 32'h0000D001);
        // R5 disabled write ignored
        io_write(AP, mk_sel(0, 0, 3, 0, 1));
        io_write(DP, 32'h4);
        io_write(AP, mk_sel(1, 0, 3, 0, 1));
        io_read(DP, d); check("R5 disabled write ignored", d, 32'h0);
        // R9 other address and hold
        io_read(16'h0CF4, d); check("R9 other address", d, 32'hFFFFFFFF);
        io_read(AP, d);
        repeat (4) @(negedge clk);
        check("R9 read data held", io_rdata, d);

        // Random mix against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            logic [15:0] a;
            r = $urandom;
            a = (r[1:0] == 2'd0) ? AP : (r[1:0] == 2'd3 ? 16'(r[31:20]) : DP);
            if (r[2]) begin
                logic [31:0] w;
                if (a == AP)
                    w = mk_sel(r[3] | r[4], r[5] ? int'(r[13:6]) : 0, r[14] ? int'(r[19:15]) : 3,
                               r[20] ? int'(r[23:21]) : 0,
                               r[24] ? int'(r[30:25]) : (r[26] ? 1 : 4));
                else
                    w = $urandom;
                io_write(a, w);
            end else begin
                rd_chk("R2 R4 R6 R7 R8 random read", a);
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule